// File: doc/BRIEF.md
# Timer Count-Enable Selector

This block decides on which system clock cycles a timer counter may advance. A 3-bit selector picks one of eight sources: stopped, every cycle, one of four fixed divisions of the system clock, or a chosen edge of an external pin. The result is a registered enable pulse, one system clock wide. The counter that consumes the pulse sits outside this block.

A 10-bit prescaler counts on every system clock whatever the selector holds. It provides the divided sources. A synchronous clear input sets it back to zero, so that a newly chosen ratio starts from a known phase. The external pin is sampled into the system clock domain through a two-flop synchronizer and is never used as a clock. One further flop holds the previous synchronized level so that edges can be detected.

Top module: `tmr_clk_sel`

## Requirements
- R1: While `rst_n` is low, `cnt_en` is 0 and the prescaler is held at zero.
- R2: When `sel` is 3'b000 at a clock edge, `cnt_en` is 0 after that edge.
- R3: When `sel` is 3'b001 at a clock edge, `cnt_en` is 1 after that edge.
- R4: When `sel` is 3'b010, 3'b011, 3'b100 or 3'b101 at a clock edge, `cnt_en` is 1 after that edge exactly when the prescaler value at that edge is a multiple of 8, 64, 256 or 1024 respectively. This gives one pulse per period.
- R5: The prescaler advances by one on every clock edge for every `sel` value and wraps from 1023 to 0.
- R6: When `psc_clr` is 1 at a clock edge, the prescaler is 0 after that edge. A divided source therefore pulses after the next edge.
- R7: With `sel` = 3'b110, a falling edge on `ext_pin` makes `cnt_en` 1 for exactly one cycle, after the third clock edge that follows the change.
- R8: With `sel` = 3'b111, a rising edge on `ext_pin` makes `cnt_en` 1 for exactly one cycle, after the third clock edge that follows the change.
- R9: A steady `ext_pin` produces no pulse. An edge of the polarity that is not selected produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 3 | Count source code (see R2 to R8) |
| psc_clr | input | 1 | Synchronous prescaler clear |
| ext_pin | input | 1 | External count pin, asynchronous to `clk` |
| cnt_en | output | 1 | Count-enable pulse for the timer counter |

## Verification
Each divided code is run for two full periods directly after a prescaler clear. This separates the four tap widths from one another and from a tap that is off by one bit. One run moves from the stop code to divide-by-8 without a clear. It shows whether the prescaler kept counting while the timer was stopped. The pin codes get isolated edges, back-to-back toggles and long steady levels, which separate the two polarities and detect doubled or missing pulses. A long stretch with a random selector, random pin toggles and random clears is then compared on every cycle with a reference model in the bench.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } cs_code_e;

  localparam int N_TAPS = 4;

  // number of low prescaler bits that must be zero for tap idx
  function automatic int tap_log2(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  // tap index used by a divided code
  function automatic int code_to_tap(input cs_code_e c);
    return int'(c) - int'(CS_DIV8);
  endfunction

endpackage

// File: rtl/psc_counter.sv
module psc_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= q + 1'b1;
  end
endmodule

// File: rtl/psc_taps.sv
module psc_taps
  import tcs_pkg::*;
#(
  parameter int W = 10,
  parameter int N = N_TAPS
) (
  input  logic [W-1:0] q,
  output logic [N-1:0] tick
);
  for (genvar i = 0; i < N; i++) begin : g_tap
    localparam int LG = tap_log2(i);
    assign tick[i] = ~|q[LG-1:0];
  end
endmodule

// File: rtl/pin_edge.sv
module pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  // chain[0..STAGES-1] synchronize, chain[STAGES] holds previous level
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign rise =  chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tcs_pkg::*;
#(
  parameter int PSC_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       psc_clr,
  input  logic       ext_pin,
  output logic       cnt_en
);
  logic [PSC_W-1:0]  psc_q;
  logic [N_TAPS-1:0] tap_tick;
  logic              rise_evt;
  logic              fall_evt;
  logic              en_next;
  cs_code_e          code;

  psc_counter #(.W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .clr(psc_clr), .q(psc_q)
  );

  psc_taps #(.W(PSC_W), .N(N_TAPS)) u_taps (
    .q(psc_q), .tick(tap_tick)
  );

  pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(rise_evt), .fall(fall_evt)
  );

  assign code = cs_code_e'(sel);

  always_comb begin
    case (code)
      CS_STOP:     en_next = 1'b0;
      CS_DIV1:     en_next = 1'b1;
      CS_DIV8,
      CS_DIV64,
      CS_DIV256,
      CS_DIV1024:  en_next = tap_tick[code_to_tap(code)];
      CS_EXT_FALL: en_next = fall_evt;
      CS_EXT_RISE: en_next = rise_evt;
      default:     en_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_en <= 1'b0;
    else        cnt_en <= en_next;
  end
endmodule

// File: rtl/tcs_chk.sv
module tcs_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   sel,
  input logic         psc_clr,
  input logic         cnt_en,
  input logic [W-1:0] psc_q,
  input logic         rise_evt,
  input logic         fall_evt
);
  // R2
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0) |=> !cnt_en);

  // R3
  div1_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd1) |=> cnt_en);

  // R4
  div8_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd2 && psc_q[2:0] != 3'd0) |=> !cnt_en);

  // R5
  psc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psc_clr |=> psc_q == W'($past(psc_q) + 1'b1));

  // R6
  psc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psc_clr |=> psc_q == '0);

  // R9
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_evt, fall_evt}));

  // R8
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);

  // R7
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);
endmodule

bind tmr_clk_sel tcs_chk #(.W(PSC_W)) u_chk (.*);

// File: tb/tb_tmr_clk_sel.sv
module tb_tmr_clk_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       psc_clr = 1'b0;
  logic       ext_pin = 1'b0;
  logic       cnt_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R2";

  tmr_clk_sel dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .psc_clr(psc_clr),
    .ext_pin(ext_pin), .cnt_en(cnt_en)
  );

  always #10 clk = ~clk;

  // reference model built from the requirements
  int unsigned m_q;
  logic [2:0] pin_h;   // pin samples: [0] newest
  logic       m_en;

  function automatic logic expect_en(input logic [2:0] s, input int unsigned q,
                                     input logic rise, input logic fall);
    int unsigned div;
    case (s)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd6: return fall;
      3'd7: return rise;
      default: begin
        div = (s == 3'd2) ? 8 : (s == 3'd3) ? 64 : (s == 3'd4) ? 256 : 1024;
        return (q % div) == 0;
      end
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd6: return "R7";
      3'd7: return "R8";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q   <= 0;
      pin_h <= '0;
      m_en  <= 1'b0;
    end else begin
      m_en  <= expect_en(sel, m_q, pin_h[1] && !pin_h[2], !pin_h[1] && pin_h[2]);
      m_q   <= psc_clr ? 0 : (m_q + 1) % 1024;
      pin_h <= {pin_h[1:0], ext_pin};
    end
  end

  logic [2:0] sel_seen;
  always @(posedge clk) sel_seen <= sel;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: cnt_en=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done)
      check((tag == "") ? req_of(sel_seen) : tag, cnt_en, m_en);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (cnt_en) cnt++;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    int p;
    void'($urandom(32'd4242));
    // R1: held in reset
    repeat (3) begin
      @(negedge clk);
      check("R1", cnt_en, 1'b0);
    end
    rst_n = 1'b1;
    tag = "R2"; step(20);
    tag = "R3"; sel = 3'd1; step(10);
    // R4 and R6: each divided code from a cleared prescaler
    for (int c = 2; c <= 5; c++) begin
      tag = "R6";
      sel = c[2:0]; psc_clr = 1'b1; step(1); psc_clr = 1'b0;
      step(2);
      tag = "R4";
      step((c == 2) ? 20 : (c == 3) ? 140 : (c == 4) ? 520 : 2060);
    end
    // R5: prescaler keeps running while stopped
    tag = "R5"; sel = 3'd0; step(37); sel = 3'd2; step(40);
    // R8: rising edges with varied spacing
    tag = "R8"; sel = 3'd7;
    ext_pin = 1'b1; step(6); ext_pin = 1'b0; step(6);
    ext_pin = 1'b1; step(1); ext_pin = 1'b0; step(1); ext_pin = 1'b1; step(8);
    // R7: falling edges
    tag = "R7"; sel = 3'd6;
    ext_pin = 1'b0; step(6); ext_pin = 1'b1; step(2); ext_pin = 1'b0; step(8);
    // R9: steady pin and wrong-polarity edge give no pulse
    tag = "R9";
    ext_pin = 1'b1; step(6);
    count_pulses(30, p); checks++;
    if (p != 0) begin errors++; $display("FAIL R9: pulses=%0d expected 0", p); end
    sel = 3'd7; ext_pin = 1'b0; count_pulses(30, p); checks++;
    if (p != 0) begin errors++; $display("FAIL R9: pulses=%0d expected 0", p); end
    ext_pin = 1'b1; count_pulses(30, p); checks++;
    if (p != 1) begin errors++; $display("FAIL R8: pulses=%0d expected 1", p); end
    // random mix
    tag = "";
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 59) == 0) sel = 3'($urandom_range(0, 7));
      psc_clr = ($urandom_range(0, 199) == 0);
      if ($urandom_range(0, 3) == 0) ext_pin = ~ext_pin;
      step(1);
    end
    psc_clr = 1'b0;
    step(2);
    finish_run();
  end
endmodule